// File: doc/BRIEF.md
# Nested Interrupt Level Tracker

This block keeps a record of the interrupt priority levels that the processor is servicing at the moment. It keeps one flag for each level. The interrupt controller raises a single-cycle accept strobe with a 3-bit level code each time it hands a maskable interrupt to the processor. It raises a separate strobe when it hands over a non-maskable interrupt. Each strobe sets the matching flag in the next clock cycle. When several flags are set together, the handlers are nested.

A handler ends with a software write to the 8-bit register. The data value does not matter. The write clears only the flag of the highest level that is set, so the flags behave as a stack of nested priorities. From the flags the block derives a current-level code and a per-level enable mask. The request logic uses the mask to block any maskable request at or below the level in service.

The current-level code is an enumerated state, and the flags decide its value: `LVL_IDLE` (0), `LVL_M1` to `LVL_M4` (1 to 4) and `LVL_NMI` (5). It moves as follows:
- An accept strobe above the current state moves it upward.
- A write moves it down to the next flag still set, or to `LVL_IDLE`.
- An accept strobe at or below the current state leaves the state unchanged.

Top module: `irq_level_stack`

## Requirements
- R1: After reset every flag is 0, `rd_data` reads 0x00, `cur_level` is 0 and `lvl_enable` is 4'b1111.
- R2: An `acc_strobe` with `acc_level` L in 1..4 sets register bit L-1 in the next cycle. If that bit is already set, it stays set.
- R3: A `nmi_accept` pulse sets register bit 7 in the next cycle.
- R4: Register bits 6..4 always read 0, whatever data is written. Level codes 0, 5, 6 and 7 on `acc_level` change nothing.
- R5: A write clears exactly one flag in the next cycle, whatever the value of `wr_data`. It clears bit 7 if that bit is set, otherwise the highest set bit among bits 3..0.
- R6: A write while no flag is set has no effect.
- R7: Without a write no flag is ever cleared, so nested levels stay set together.
- R8: `cur_level` is 5 when bit 7 is set. Otherwise it is the number of the highest set maskable level, or 0 when no flag is set.
- R9: `lvl_enable[i]` (level i+1) is 1 exactly when i+1 is greater than `cur_level`, so it is all zero while a non-maskable interrupt is in service.
- R10: When an accept and a write fall in the same cycle, the clear uses the flags from before that cycle and the accepted flag is set afterwards, so the accept is never lost.
- R11: `rd_data` shows the current flags. Reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe | input | 1 | Maskable interrupt accepted this cycle |
| acc_level | input | 3 | Level code of the accepted maskable interrupt (1..4 valid) |
| nmi_accept | input | 1 | Non-maskable interrupt accepted this cycle |
| wr_en | input | 1 | Software write to the register (end of handler) |
| wr_data | input | 8 | Write data (value ignored) |
| rd_data | output | 8 | Register view: bit 7 non-maskable, bits 3..0 levels 4..1 |
| cur_level | output | 3 | Highest level in service (0 idle, 1..4, 5 non-maskable) |
| lvl_enable | output | 4 | Per-level request enable, bit i for level i+1 |

## Verification
The end-of-handler clear and a new accept can fall in the same clock cycle. The bench drives `wr_en` together with `acc_strobe` or `nmi_accept` on the same falling edge. It covers three cases:
- the accepted level is below the level being cleared;
- the accepted level is the same as the level being cleared;
- a non-maskable accept arrives while the non-maskable flag is set.

A reference model in the bench first removes the highest flag from the old set and then adds the accepted one. The bench compares `rd_data`, `cur_level` and `lvl_enable` with that model one clock later.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    localparam int NUM_MLVL  = 4;
    localparam int NUM_FLAGS = NUM_MLVL + 1;
    localparam int LVL_W     = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_IDLE = 3'd0,
        LVL_M1   = 3'd1,
        LVL_M2   = 3'd2,
        LVL_M3   = 3'd3,
        LVL_M4   = 3'd4,
        LVL_NMI  = 3'd5
    } lvl_code_e;

endpackage

// File: rtl/irq_lvl_flags.sv
module irq_lvl_flags
    import irq_lvl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic [NUM_FLAGS-1:0] clr_vec,
    output logic [NUM_FLAGS-1:0] flags
);

    // The clear acts on the old flags and the set is applied last (R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

    // R7: with nothing to clear, every flag that was set stays set.
    a_r7_no_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/irq_lvl_prio.sv
module irq_lvl_prio
    import irq_lvl_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] top_onehot,
    output lvl_code_e            lvl_code
);

    always_comb begin
        top_onehot = '0;
        lvl_code   = LVL_IDLE;
        for (int i = 0; i < NUM_MLVL; i++) begin
            if (flags[i]) begin
                top_onehot    = '0;
                top_onehot[i] = 1'b1;
                lvl_code      = lvl_code_e'(LVL_W'(i + 1));
            end
        end
        if (flags[NUM_MLVL]) begin
            top_onehot           = '0;
            top_onehot[NUM_MLVL] = 1'b1;
            lvl_code             = LVL_NMI;
        end
    end

endmodule

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate
    import irq_lvl_pkg::*;
(
    input  lvl_code_e            lvl_code,
    output logic [NUM_MLVL-1:0]  lvl_enable
);

    for (genvar i = 0; i < NUM_MLVL; i++) begin : g_en
        localparam logic [LVL_W-1:0] THR = LVL_W'(i + 1);
        assign lvl_enable[i] = (lvl_code < THR);
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_lvl_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int NMI_BIT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_strobe,
    input  logic [LVL_W-1:0]     acc_level,
    input  logic                 nmi_accept,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic [LVL_W-1:0]     cur_level,
    output logic [NUM_MLVL-1:0]  lvl_enable
);

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] top_onehot;
    lvl_code_e            lvl_code;
    logic                 unused_wr_data;

    // The data value of a write carries no meaning.
    assign unused_wr_data = ^wr_data;

    // Decode the accept strobes into set requests.
    for (genvar i = 0; i < NUM_MLVL; i++) begin : g_set
        localparam logic [LVL_W-1:0] CODE = LVL_W'(i + 1);
        assign set_vec[i] = acc_strobe && (acc_level == CODE);
    end
    assign set_vec[NUM_MLVL] = nmi_accept;

    // A write clears only the highest flag that is set.
    assign clr_vec = wr_en ? top_onehot : '0;

    irq_lvl_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    irq_lvl_prio u_prio (
        .flags      (flags),
        .top_onehot (top_onehot),
        .lvl_code   (lvl_code)
    );

    irq_lvl_gate u_gate (
        .lvl_code   (lvl_code),
        .lvl_enable (lvl_enable)
    );

    always_comb begin
        rd_data                 = '0;
        rd_data[NMI_BIT]        = flags[NUM_MLVL];
        rd_data[NUM_MLVL-1:0]   = flags[NUM_MLVL-1:0];
    end

    assign cur_level = lvl_code;

    // R2 and R10: an accepted level is set one cycle later, even when a write falls in the same cycle.
    a_r10_accept_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R3: a non-maskable accept leads to the non-maskable level.
    a_r3_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_accept |=> (rd_data[NMI_BIT] && cur_level == LVL_NMI));

    // R4: the reserved bits read as zero.
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[NMI_BIT-1:NUM_MLVL] == '0);

    // R5: a write with no accept in the same cycle removes exactly one flag.
    a_r5_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_strobe && !nmi_accept && flags != '0)
        |=> ($countones(flags) + 1 == $countones($past(flags))));

    // R6: a write while no flag is set leaves every flag at zero.
    a_r6_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_strobe && !nmi_accept && flags == '0) |=> (flags == '0));

    // R9: non-maskable service blocks every maskable level, and idle blocks none.
    a_r9_gate_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == LVL_NMI) |-> (lvl_enable == '0));
    a_r9_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == LVL_IDLE) |-> (lvl_enable == '1));

endmodule

// File: tb/irq_level_stack_test.sv
module irq_level_stack_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_strobe = 1'b0;
    logic [2:0] acc_level = 3'd0;
    logic       nmi_accept = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [2:0] cur_level;
    logic [3:0] lvl_enable;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [14:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    // Reference model: bit 4 is the non-maskable flag, bits 3..0 are levels 4..1.
    logic [4:0] m_flags = 5'd0;

    always #10 clk = ~clk;

    irq_level_stack uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_strobe (acc_strobe),
        .acc_level  (acc_level),
        .nmi_accept (nmi_accept),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .cur_level  (cur_level),
        .lvl_enable (lvl_enable)
    );

    function automatic logic [14:0] expect_of(input logic [4:0] f);
        logic [7:0] rd;
        logic [2:0] lv;
        logic [3:0] en;
        rd = {f[4], 3'b000, f[3:0]};
        if (f[4]) lv = 3'd5;
        else if (f[3]) lv = 3'd4;
        else if (f[2]) lv = 3'd3;
        else if (f[1]) lv = 3'd2;
        else if (f[0]) lv = 3'd1;
        else lv = 3'd0;
        for (int i = 0; i < 4; i++) en[i] = ((i + 1) > lv);
        return {rd, lv, en};
    endfunction

    task automatic report(input logic [14:0] act, input logic [14:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual rd=%h lvl=%0d en=%b expected rd=%h lvl=%0d en=%b",
                     tag, act[14:7], act[6:4], act[3:0], exp[14:7], exp[6:4], exp[3:0]);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(input logic acc, input logic [2:0] lvl, input logic nmi,
                        input logic wr, input logic [7:0] data, input string tag);
        logic [4:0] nf;
        @(negedge clk);
        acc_strobe = acc;
        acc_level  = lvl;
        nmi_accept = nmi;
        wr_en      = wr;
        wr_data    = data;
        nf = m_flags;
        if (wr) begin
            if (nf[4]) nf[4] = 1'b0;
            else if (nf[3]) nf[3] = 1'b0;
            else if (nf[2]) nf[2] = 1'b0;
            else if (nf[1]) nf[1] = 1'b0;
            else if (nf[0]) nf[0] = 1'b0;
        end
        if (acc && lvl >= 3'd1 && lvl <= 3'd4) nf[lvl - 3'd1] = 1'b1;
        if (nmi) nf[4] = 1'b1;
        m_flags = nf;
        sb_q.push_back('{exp: expect_of(nf), tag: tag});
    endtask

    // Monitor: compares the outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                report({rd_data, cur_level, lvl_enable}, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        report({rd_data, cur_level, lvl_enable}, {8'h00, 3'd0, 4'b1111}, "R1 reset state");

        step(1, 3'd2, 0, 0, 8'h00, "R2 accept level 2");
        step(1, 3'd2, 0, 0, 8'h00, "R2 re-accept level 2");
        step(1, 3'd4, 0, 0, 8'h00, "R7 R8 nest level 4");
        step(0, 3'd0, 0, 0, 8'h00, "R7 hold without write");
        step(1, 3'd0, 0, 0, 8'h00, "R4 level code 0 ignored");
        step(1, 3'd5, 0, 0, 8'h00, "R4 level code 5 ignored");
        step(1, 3'd7, 0, 0, 8'h00, "R4 level code 7 ignored");
        step(0, 3'd0, 1, 0, 8'h00, "R3 R9 non-maskable accept");
        step(0, 3'd0, 0, 1, 8'hFF, "R5 write clears non-maskable first");
        step(0, 3'd0, 0, 1, 8'h70, "R4 R5 write clears level 4, reserved stay 0");
        step(0, 3'd0, 0, 0, 8'h00, "R11 read without side effect");
        step(0, 3'd0, 0, 1, 8'h00, "R5 write clears level 2");
        step(0, 3'd0, 0, 1, 8'hA5, "R6 write with no flag set");
        step(1, 3'd1, 0, 0, 8'h00, "R2 accept level 1");
        step(1, 3'd3, 0, 0, 8'h00, "R9 nest level 3");
        step(1, 3'd2, 0, 1, 8'h00, "R10 write with lower accept");
        step(1, 3'd2, 0, 1, 8'h00, "R10 write with same-level accept");
        step(0, 3'd0, 1, 0, 8'h00, "R3 non-maskable over nest");
        step(0, 3'd0, 1, 1, 8'h3C, "R10 write with non-maskable accept");
        step(1, 3'd4, 0, 0, 8'h00, "R8 level 4 under non-maskable");
        step(0, 3'd0, 0, 1, 8'h00, "R5 clear non-maskable");
        step(0, 3'd0, 0, 1, 8'h00, "R5 clear level 4");
        step(0, 3'd0, 0, 1, 8'h00, "R5 clear level 2");
        step(0, 3'd0, 0, 1, 8'h00, "R5 clear level 1");
        step(0, 3'd0, 0, 1, 8'h00, "R6 empty again");
        for (int l = 1; l <= 4; l++) begin
            step(1, 3'(l), 0, 0, 8'h00, "R2 R9 ascending accept");
        end
        step(0, 3'd0, 0, 0, 8'h00, "R7 idle drain");
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule